// File: doc/BRIEF.md
# Capability-Checked Segment Address Translator

This block turns a 64-bit virtual address into a physical address for a 64-bit core that puts a capability bounds check in front of address translation. Each request carries the virtual address, a 2-bit access kind and the 257-bit program counter capability. The block reads the base from bits 127..64 of the capability and the length from bits 63..0. If the access fits inside the length, the block adds the base to the address and decodes the sum by fixed segment. Only the direct-physical window and the two unmapped 32-bit compatibility windows produce an address. Every mapped region reports an address error, because no TLB sits behind this block.

Requests are single-cycle strobes. A registered result comes back one cycle later with a one-cycle valid pulse. The result holds either a physical address or an exception flag with a cause code. Back-to-back requests are accepted on every cycle.

The control is a two-state machine. `ST_IDLE` means no result is being presented. `ST_DONE` means a result is presented this cycle. `IDLE->DONE` and `DONE->DONE` are taken on a request strobe. `DONE->IDLE` and `IDLE->IDLE` are taken when no request arrives.

Top module: `cap_seg_xlate`

## Requirements
- R1: While reset is active and after it is released with no request, `rsp_valid`, `rsp_exc` and `rsp_cause` are 0 and `rsp_paddr` is 0.
- R2: `rsp_valid` is high in exactly the cycle after each cycle in which `req_valid` is high, and low otherwise. Back-to-back requests give back-to-back results.
- R3: The access raises a length violation (cause 3, `rsp_exc`=1, address 0) when the unsigned address plus 4 exceeds the unsigned length. The sum is computed without overflow. An access where address plus 4 equals the length is allowed.
- R4: A length violation takes priority over any segment fault, and segment decode is then not used.
- R5: The decoded address is base plus virtual address, taken modulo 2^64.
- R6: Decoded addresses with bits 63..62 equal to 00 or 01 always fault with an address error.
- R7: When bits 63..62 are 10, the physical address is bits 58..0 zero-extended. Bits 61..59 have no effect.
- R8: When bits 63..62 are 11, bits 61..31 are all ones and bits 30..29 are 00 or 01, the physical address is bits 28..0 zero-extended.
- R9: Under prefix 11, any other pattern faults with an address error. This covers bits 30..29 equal to 10 or 11, and bits 61..31 that are not all ones.
- R10: Access kind encoding is 00 fetch, 01 load, 10 store, 11 treated as load. The address-error cause is 2 for a store and 1 for every other kind.
- R11: When `rsp_exc` is 1, `rsp_paddr` is 0 and `rsp_cause` is nonzero. When `rsp_exc` is 0, `rsp_cause` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_vaddr | input | 64 | Virtual address |
| req_kind | input | 2 | Access kind: 00 fetch, 01 load, 10 store, 11 load |
| req_pcc | input | 257 | Program counter capability; base in 127..64, length in 63..0 |
| rsp_valid | output | 1 | Result pulse, one cycle after the request |
| rsp_paddr | output | 64 | Physical address, zero on exception |
| rsp_exc | output | 1 | Exception flag |
| rsp_cause | output | 2 | 0 none, 1 load/fetch address error, 2 store address error, 3 length violation |

## Verification
Two situations are hard to reach from the ports. The first is the carry out of bit 63 when the base is added to the address. The second is the exact length limit, where the address plus 4 equals the length. Neither happens with a zero base and a full-range length. The stimulus therefore programs the capability length to 0x1000 and probes 0xFFC and 0xFFD. It also uses a near-maximum address, whose plus-4 sum would wrap if computed on only 64 bits. Bases near 2^64 are chosen so that the wrapped sum lands in the direct-physical window, and a second case lands it in a faulting user region.

// File: rtl/cap_xlate_pkg.sv
`timescale 1ns/1ps
package cap_xlate_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_LOAD  = 2'b01,
        ACC_STORE = 2'b10,
        ACC_ALT   = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        CAUSE_NONE       = 2'd0,
        CAUSE_ADDR_LOAD  = 2'd1,
        CAUSE_ADDR_STORE = 2'd2,
        CAUSE_CAP_LEN    = 2'd3
    } cause_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } xl_state_e;

endpackage

// File: rtl/cap_len_check.sv
`timescale 1ns/1ps
module cap_len_check #(
    parameter int ADDR_W = 64,
    parameter int SPAN   = 4
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [ADDR_W-1:0] limit,
    output logic              over
);
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] end_ext;

    // One extra bit keeps the end of the access from wrapping.
    assign end_ext = {1'b0, vaddr} + EXT_W'(SPAN);
    assign over    = end_ext > {1'b0, limit};
endmodule

// File: rtl/cap_seg_decode.sv
`timescale 1ns/1ps
module cap_seg_decode #(
    parameter int ADDR_W   = 64,
    parameter int DIRECT_W = 59,
    parameter int COMPAT_W = 29
) (
    input  logic [ADDR_W-1:0] eff,
    output logic              fault,
    output logic [ADDR_W-1:0] paddr
);
    localparam int SEL_LO = COMPAT_W;
    localparam int PFX_LO = COMPAT_W + 2;
    localparam int PFX_HI = ADDR_W - 3;
    localparam int PFX_W  = PFX_HI - PFX_LO + 1;

    logic [1:0]       region;
    logic             pfx_ones;
    logic [1:0]       win_sel;

    assign region   = eff[ADDR_W-1 -: 2];
    assign pfx_ones = (eff[PFX_HI:PFX_LO] == {PFX_W{1'b1}});
    assign win_sel  = eff[SEL_LO +: 2];

    always_comb begin
        fault = 1'b1;
        paddr = '0;
        unique case (region)
            2'b10: begin
                fault                = 1'b0;
                paddr[DIRECT_W-1:0]  = eff[DIRECT_W-1:0];
            end
            2'b11: begin
                if (pfx_ones && !win_sel[1]) begin
                    fault                = 1'b0;
                    paddr[COMPAT_W-1:0]  = eff[COMPAT_W-1:0];
                end
            end
            default: begin
                fault = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/cap_seg_xlate.sv
`timescale 1ns/1ps
module cap_seg_xlate
    import cap_xlate_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int CAP_W    = 257,
    parameter int SPAN     = 4,
    parameter int DIRECT_W = 59,
    parameter int COMPAT_W = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        req_kind,
    input  logic [CAP_W-1:0]  req_pcc,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_exc,
    output logic [1:0]        rsp_cause
);
    localparam int BASE_LO = ADDR_W;
    localparam int CAP_TOP = 2 * ADDR_W;

    xl_state_e         state_q, state_nx;
    logic [ADDR_W-1:0] cap_base, cap_len, eff_addr, seg_pa, res_pa;
    logic              len_over, seg_fault;
    cause_e            res_cause;
    logic              unused_cap_hi;

    assign cap_base      = req_pcc[BASE_LO +: ADDR_W];
    assign cap_len       = req_pcc[ADDR_W-1:0];
    assign unused_cap_hi = ^req_pcc[CAP_W-1:CAP_TOP];
    assign eff_addr      = cap_base + req_vaddr;

    cap_len_check #(.ADDR_W(ADDR_W), .SPAN(SPAN)) u_len (
        .vaddr (req_vaddr),
        .limit (cap_len),
        .over  (len_over)
    );

    cap_seg_decode #(.ADDR_W(ADDR_W), .DIRECT_W(DIRECT_W), .COMPAT_W(COMPAT_W)) u_seg (
        .eff   (eff_addr),
        .fault (seg_fault),
        .paddr (seg_pa)
    );

    always_comb begin
        res_cause = CAUSE_NONE;
        res_pa    = seg_pa;
        if (len_over) begin
            res_cause = CAUSE_CAP_LEN;
            res_pa    = '0;
        end else if (seg_fault) begin
            res_cause = (acc_kind_e'(req_kind) == ACC_STORE) ? CAUSE_ADDR_STORE
                                                             : CAUSE_ADDR_LOAD;
            res_pa    = '0;
        end
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: state_nx = req_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_nx = req_valid ? ST_DONE : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_paddr <= '0;
            rsp_exc   <= 1'b0;
            rsp_cause <= 2'd0;
        end else if (req_valid) begin
            rsp_paddr <= res_pa;
            rsp_exc   <= (res_cause != CAUSE_NONE);
            rsp_cause <= res_cause;
        end
    end

    assign rsp_valid = (state_q == ST_DONE);
endmodule

// File: rtl/cap_seg_xlate_chk.sv
`timescale 1ns/1ps
module cap_seg_xlate_chk #(
    parameter int ADDR_W = 64,
    parameter int CAP_W  = 257
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_vaddr,
    input logic [1:0]        req_kind,
    input logic [CAP_W-1:0]  req_pcc,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic              rsp_exc,
    input logic [1:0]        rsp_cause
);
    logic              c_over;
    logic [ADDR_W-1:0] c_eff;

    assign c_over = ({1'b0, req_vaddr} + (ADDR_W+1)'(4)) > {1'b0, req_pcc[ADDR_W-1:0]};
    assign c_eff  = req_pcc[ADDR_W +: ADDR_W] + req_vaddr;

    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_len_violation_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && c_over) |=> (rsp_exc && rsp_cause == 2'd3));
    assert_len_allowed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !c_over) |=> (rsp_cause != 2'd3));
    assert_low_region_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !c_over && !c_eff[ADDR_W-1]) |=> rsp_exc);
    assert_store_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !c_over && !c_eff[ADDR_W-1] && req_kind == 2'b10) |=> (rsp_cause == 2'd2));
    assert_exc_zero_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_exc) |-> (rsp_paddr == '0));
    assert_exc_flag_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_exc == (rsp_cause != 2'd0)));
endmodule

bind cap_seg_xlate cap_seg_xlate_chk #(.ADDR_W(ADDR_W), .CAP_W(CAP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_vaddr (req_vaddr),
    .req_kind  (req_kind),
    .req_pcc   (req_pcc),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_exc   (rsp_exc),
    .rsp_cause (rsp_cause)
);

// File: tb/cap_seg_xlate_tb_top.sv
`timescale 1ns/1ps
module cap_seg_xlate_tb_top;
    localparam logic [63:0] MX = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] HB = 64'h8000_0000_0000_0000;

    typedef struct packed {
        logic [63:0] va;
        logic [1:0]  kind;
        logic [63:0] base;
        logic [63:0] len;
        logic [1:0]  cause;
        logic [63:0] pa;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{64'h0000_0000_0000_1000, 2'b00, 64'h0, MX, 2'd1, 64'h0, 4'd6},        // R6 user, fetch
        '{64'h0000_0000_0000_1000, 2'b10, 64'h0, MX, 2'd2, 64'h0, 4'd10},       // R10 store cause
        '{64'h4000_0000_0000_0000, 2'b01, 64'h0, MX, 2'd1, 64'h0, 4'd6},        // R6 supervisor
        '{64'h3FFF_FFFF_FFFF_FFF0, 2'b11, 64'h0, MX, 2'd1, 64'h0, 4'd10},       // R10 kind 11 as load
        '{64'h7FFF_FFFF_FFFF_FFF0, 2'b10, 64'h0, MX, 2'd2, 64'h0, 4'd6},        // R6 top of 01
        '{64'h8000_0000_0000_0000, 2'b01, 64'h0, MX, 2'd0, 64'h0, 4'd7},        // R7 bottom of direct
        '{64'hB800_0000_1234_5678, 2'b10, 64'h0, MX, 2'd0, 64'h1234_5678, 4'd7},// R7 cache bits ignored
        '{64'hBFFF_FFFF_FFFF_FFF0, 2'b00, 64'h0, MX, 2'd0, 64'h07FF_FFFF_FFFF_FFF0, 4'd7}, // R7 top
        '{64'hFFFF_FFFF_8000_0000, 2'b00, 64'h0, MX, 2'd0, 64'h0, 4'd8},        // R8 window 00 start
        '{64'hFFFF_FFFF_BFFF_FFFC, 2'b01, 64'h0, MX, 2'd0, 64'h1FFF_FFFC, 4'd8},// R8 window 01 end
        '{64'hFFFF_FFFF_C000_0000, 2'b10, 64'h0, MX, 2'd2, 64'h0, 4'd9},        // R9 window 10
        '{64'hFFFF_FFFF_E000_0000, 2'b01, 64'h0, MX, 2'd1, 64'h0, 4'd9},        // R9 window 11
        '{64'hFFFF_FFFF_7FFF_FFF0, 2'b01, 64'h0, MX, 2'd1, 64'h0, 4'd9},        // R9 prefix not all ones
        '{64'hC000_0000_0000_0000, 2'b00, 64'h0, MX, 2'd1, 64'h0, 4'd9},        // R9 bottom of 11
        '{64'h0000_0000_0000_0FFC, 2'b01, HB, 64'h1000, 2'd0, 64'hFFC, 4'd3},  // R3 exact limit allowed
        '{64'h0000_0000_0000_0FFD, 2'b01, HB, 64'h1000, 2'd3, 64'h0, 4'd3},    // R3 one past limit
        '{64'hFFFF_FFFF_FFFF_FFFE, 2'b10, HB, 64'h1000, 2'd3, 64'h0, 4'd3},    // R3 no overflow in +4
        '{64'h0000_0000_0000_0020, 2'b10, 64'h0, 64'h10, 2'd3, 64'h0, 4'd4},   // R4 len beats store fault
        '{64'h8000_0000_0000_0200, 2'b01, 64'hFFFF_FFFF_FFFF_FF00, MX, 2'd0, 64'h100, 4'd5}, // R5 wrap to direct
        '{64'h8000_0000_0000_1000, 2'b00, 64'h7FFF_FFFF_8000_0000, MX, 2'd0, 64'h1000, 4'd5}, // R5 carry into compat
        '{64'h7000_0000_0000_0010, 2'b10, 64'h9000_0000_0000_0000, MX, 2'd2, 64'h0, 4'd5}     // R5 wrap to user
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [63:0]  req_vaddr = '0;
    logic [1:0]   req_kind = '0;
    logic [256:0] req_pcc = '0;
    logic         rsp_valid;
    logic [63:0]  rsp_paddr;
    logic         rsp_exc;
    logic [1:0]   rsp_cause;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cap_seg_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_pcc(req_pcc), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_exc(rsp_exc), .rsp_cause(rsp_cause)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        req_valid = 1'b1;
        req_vaddr = v.va;
        req_kind  = v.kind;
        req_pcc   = {1'b0, 64'h0, 64'h0, v.base, v.len};
    endtask

    task automatic check_rsp(input vec_t v, input int idx);
        string t;
        t = $sformatf("R%0d vec%0d", v.rq, idx);
        chk({t, " valid (R2)"}, 64'(rsp_valid), 64'd1);
        chk({t, " cause"}, 64'(rsp_cause), 64'(v.cause));
        chk({t, " exc (R11)"}, 64'(rsp_exc), 64'(v.cause != 2'd0));
        chk({t, " paddr"}, rsp_paddr, v.pa);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while held
        chk("R1 valid in reset", 64'(rsp_valid), 64'd0);
        chk("R1 exc in reset", 64'(rsp_exc), 64'd0);
        chk("R1 cause in reset", 64'(rsp_cause), 64'd0);
        chk("R1 paddr in reset", rsp_paddr, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 valid after release", 64'(rsp_valid), 64'd0);
        chk("R2 idle no pulse", 64'(rsp_valid), 64'd0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            req_valid = 1'b0;
            check_rsp(VECS[i], i);
            @(negedge clk);
            chk("R2 single pulse", 64'(rsp_valid), 64'd0);
        end

        // R2: back-to-back requests
        drive(VECS[9]);
        @(negedge clk);
        check_rsp(VECS[9], 9);
        drive(VECS[10]);
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp(VECS[10], 10);
        @(negedge clk);
        chk("R2 pulse ends after burst", 64'(rsp_valid), 64'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule